// File: doc/BRIEF.md
# Page Write Buffer and Word Address Counter

This block sits between a serial memory's bus protocol engine and its 256-byte storage array (16 pages of 16 bytes). It keeps the internal word address counter and collects incoming write data in a one-page latch. The protocol engine drives it with single-cycle strobes: load a word address, store a received data byte, advance after a read byte, and start the write cycle after a STOP.

Write data and reads advance the counter differently. When a byte is stored, only the offset bits inside the page move, so an over-long burst wraps to the start of the same page and overwrites what came earlier. After a read byte, the whole address moves, running from FFh back to 00h. Between operations the counter holds the address after the last one accessed, so the engine can serve current-address reads directly.

A commit request starts a self-timed write cycle of fixed length. During this cycle the block reports busy and ignores every other strobe. In the first cycles of that window it walks the sixteen slots in ascending order. It issues an array write only for slots that received a byte since the last address load, and only when the externally supplied per-byte permission is high. The write-cycle length must be at least the page size.

Top module: `pageWriteBuf`

## Requirements
- R1: After reset, curAddr is 00h, busy is 0 and memWe is 0.
- R2: When idle, addrLoad sets curAddr to addrIn on the next cycle. It also discards every byte latched before it, so a later commit writes none of them.
- R3: When idle, dataValid stores dataIn in slot curAddr[3:0]. It then increments curAddr[3:0] only, from Fh to 0h, and curAddr[7:4] is unchanged.
- R4: When more than 16 bytes arrive after one address load, a later byte to a slot replaces the earlier one. The commit writes only the latest value.
- R5: When idle, readNext alone increments all 8 bits of curAddr, wrapping from FFh to 00h.
- R6: Strobes in the same cycle resolve as follows. addrLoad together with dataValid stores the byte at slot addrIn[3:0] and leaves curAddr at {addrIn[7:4], addrIn[3:0]+1}. readNext has no effect when addrLoad or dataValid is also high.
- R7: A commitStart while idle raises busy on the next cycle. Busy then stays high for exactly WR_CYCLES cycles, whether or not any byte is written.
- R8: In busy cycle k, for k from 0 to 15, memAddr is {curAddr[7:4], k} and memWdata is slot k's byte. memWe is high only if slot k was filled since the last address load and byteAllow is high.
- R9: When byteAllow is low for an address, that address is not written. The busy length is unchanged.
- R10: While busy, addrLoad, dataValid, readNext and commitStart have no effect. curAddr holds, no byte is latched, and no second write cycle follows.
- R11: At the end of a write cycle all slots become empty. A further commit with no new data writes nothing.
- R12: After a write cycle, curAddr still holds the address after the last byte stored.
- R13: dataValid in the same cycle as commitStart stores the byte, and that commit writes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| addrLoad | input | 1 | Load a new word address from addrIn |
| addrIn | input | ADDR_W | Word address to load |
| dataValid | input | 1 | A write data byte is present on dataIn |
| dataIn | input | DATA_W | Write data byte |
| readNext | input | 1 | One read byte was delivered; advance the full address |
| commitStart | input | 1 | Start the self-timed write cycle |
| byteAllow | input | 1 | Permission to write the address currently on memAddr |
| curAddr | output | ADDR_W | Current word address (next current-address read) |
| busy | output | 1 | Write cycle in progress |
| memWe | output | 1 | Array write strobe |
| memAddr | output | ADDR_W | Array write address |
| memWdata | output | DATA_W | Array write data |

## Verification
The sharpest collisions are a byte store landing in the same cycle as the commit request, and a store landing in the same cycle as an address load. Both are driven as single combined strobes in directed cases. They are judged by the final array contents and the write-strobe count, which must match a bench model that applies the store before the commit snapshot and the load before the store. A third case fires every strobe at once in the middle of a write cycle. It must leave the address, the busy length and the array untouched.

// File: rtl/pwbPkg.sv
package pwbPkg;
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic stepRead;
    logic clearMask;
  } pwbStrobe_t;
endpackage

// File: rtl/pwbCtrl.sv
module pwbCtrl
  import pwbPkg::*;
#(
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 40
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             addrLoad,
  input  logic             dataValid,
  input  logic             readNext,
  input  logic             commitStart,
  output pwbStrobe_t       strobe,
  output logic             busy,
  output logic             scanning,
  output logic [OFF_W-1:0] scanIdx
);
  localparam int PAGE_BYTES = 1 << OFF_W;
  localparam int CYC_W      = $clog2(WR_CYCLES + 1);

  logic [CYC_W-1:0] cyc;
  logic             lastCyc;

  assign lastCyc = busy && (cyc == CYC_W'(WR_CYCLES - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else if (!busy) begin
      if (commitStart) begin
        busy <= 1'b1;
        cyc  <= '0;
      end
    end else if (lastCyc) begin
      busy <= 1'b0;
      cyc  <= '0;
    end else begin
      cyc <= cyc + 1'b1;
    end
  end

  always_comb begin
    strobe.loadAddr  = addrLoad && !busy;
    strobe.storeByte = dataValid && !busy;
    strobe.stepRead  = readNext && !busy && !addrLoad && !dataValid;
    strobe.clearMask = lastCyc;
  end

  assign scanning = busy && (32'(cyc) < PAGE_BYTES);
  assign scanIdx  = cyc[OFF_W-1:0];
endmodule

// File: rtl/pwbData.sv
module pwbData
  import pwbPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int OFF_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  pwbStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [OFF_W-1:0]  scanIdx,
  output logic [ADDR_W-1:0] curAddr,
  output logic [DATA_W-1:0] slotData,
  output logic              slotValid
);
  localparam int PAGE_BYTES = 1 << OFF_W;

  logic [ADDR_W-1:0]     counter;
  logic [ADDR_W-1:0]     effAddr;
  logic [ADDR_W-1:0]     counterNext;
  logic [OFF_W-1:0]      slot;
  logic [PAGE_BYTES-1:0] validMask;
  logic [PAGE_BYTES-1:0] maskNext;
  logic [DATA_W-1:0]     latchMem [PAGE_BYTES];

  // A load in the same cycle as a store takes effect first.
  assign effAddr = strobe.loadAddr ? addrIn : counter;
  assign slot    = effAddr[OFF_W-1:0];

  always_comb begin
    counterNext = counter;
    if (strobe.storeByte)
      counterNext = {effAddr[ADDR_W-1:OFF_W], slot + OFF_W'(1)};
    else if (strobe.loadAddr)
      counterNext = addrIn;
    else if (strobe.stepRead)
      counterNext = counter + ADDR_W'(1);
  end

  always_comb begin
    maskNext = (strobe.loadAddr || strobe.clearMask) ? '0 : validMask;
    if (strobe.storeByte) maskNext[slot] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      counter   <= '0;
      validMask <= '0;
    end else begin
      counter   <= counterNext;
      validMask <= maskNext;
    end
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : gSlot
    always_ff @(posedge clk) begin
      if (!rstN)
        latchMem[g] <= '0;
      else if (strobe.storeByte && (slot == OFF_W'(g)))
        latchMem[g] <= dataIn;
    end
  end

  assign curAddr   = counter;
  assign slotData  = latchMem[scanIdx];
  assign slotValid = validMask[scanIdx];
endmodule

// File: rtl/pageWriteBuf.sv
module pageWriteBuf
  import pwbPkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 4,
  parameter int DATA_W    = 8,
  parameter int WR_CYCLES = 40
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrLoad,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              dataValid,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              readNext,
  input  logic              commitStart,
  input  logic              byteAllow,
  output logic [ADDR_W-1:0] curAddr,
  output logic              busy,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata
);
  pwbStrobe_t       strobe;
  logic             scanning;
  logic [OFF_W-1:0] scanIdx;
  logic             slotValid;

  pwbCtrl #(.OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)) u_ctrl (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .dataValid(dataValid),
    .readNext(readNext), .commitStart(commitStart), .strobe(strobe),
    .busy(busy), .scanning(scanning), .scanIdx(scanIdx)
  );

  pwbData #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addrIn), .dataIn(dataIn),
    .scanIdx(scanIdx), .curAddr(curAddr), .slotData(memWdata),
    .slotValid(slotValid)
  );

  assign memAddr = {curAddr[ADDR_W-1:OFF_W], scanIdx};
  assign memWe   = scanning && slotValid && byteAllow;
endmodule

// File: rtl/pageWriteBufChk.sv
module pageWriteBufChk #(
  parameter int ADDR_W    = 8,
  parameter int OFF_W     = 4,
  parameter int WR_CYCLES = 40
) (
  input logic              clk,
  input logic              rstN,
  input logic              addrLoad,
  input logic [ADDR_W-1:0] addrIn,
  input logic              dataValid,
  input logic              readNext,
  input logic              byteAllow,
  input logic [ADDR_W-1:0] curAddr,
  input logic              busy,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr
);
  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN) runLen <= 0;
    else       runLen <= busy ? runLen + 1 : 0;
  end

  // R7
  busy_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (runLen == WR_CYCLES));

  // R8
  we_in_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> busy);

  // R9
  we_allowed_chk: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> byteAllow);

  // R10
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(curAddr));

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(memAddr[ADDR_W-1:OFF_W]));

  // R5
  read_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (readNext && !addrLoad && !dataValid && !busy) |=>
      (curAddr == $past(curAddr) + ADDR_W'(1)));

  // R3
  write_wrap_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dataValid && !addrLoad && !busy) |=>
      ((curAddr[ADDR_W-1:OFF_W] == $past(curAddr[ADDR_W-1:OFF_W])) &&
       (curAddr[OFF_W-1:0] == $past(curAddr[OFF_W-1:0]) + OFF_W'(1))));

  // R2
  load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (addrLoad && !dataValid && !busy) |=> (curAddr == $past(addrIn)));
endmodule

bind pageWriteBuf pageWriteBufChk #(
  .ADDR_W(ADDR_W), .OFF_W(OFF_W), .WR_CYCLES(WR_CYCLES)
) u_chk (
  .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
  .dataValid(dataValid), .readNext(readNext), .byteAllow(byteAllow),
  .curAddr(curAddr), .busy(busy), .memWe(memWe), .memAddr(memAddr)
);

// File: tb/pageWriteBuf_tb.sv
`timescale 1ns/1ps
module pageWriteBuf_tb;
  localparam int WR = 40;

  logic       clk = 1'b0;
  logic       rstN;
  logic       addrLoad, dataValid, readNext, commitStart, byteAllow;
  logic [7:0] addrIn, dataIn;
  logic [7:0] curAddr, memAddr, memWdata;
  logic       busy, memWe;
  int         protMode;

  int tests = 0;
  int fails = 0;
  int weCount;

  logic [7:0] dutMem [256];
  logic [7:0] refMem [256];
  logic [7:0] refLatch [16];
  logic [15:0] refValid;
  logic [7:0] refAddr;

  always #4 clk = ~clk;

  pageWriteBuf #(.WR_CYCLES(WR)) u_dut (
    .clk(clk), .rstN(rstN), .addrLoad(addrLoad), .addrIn(addrIn),
    .dataValid(dataValid), .dataIn(dataIn), .readNext(readNext),
    .commitStart(commitStart), .byteAllow(byteAllow), .curAddr(curAddr),
    .busy(busy), .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata)
  );

  // Permission: mode 0 allows all, mode 1 allows only the upper half.
  function automatic bit allowed(int mode, logic [7:0] a);
    return (mode == 0) || a[7];
  endfunction

  assign byteAllow = allowed(protMode, memAddr);

  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 256; i++) dutMem[i] <= 8'h00;
      weCount <= 0;
    end else if (memWe) begin
      dutMem[memAddr] <= memWdata;
      weCount <= weCount + 1;
    end
  end

  task automatic chk(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chkMem(string tag);
    int bad = 0;
    int first = -1;
    for (int i = 0; i < 256; i++)
      if (dutMem[i] !== refMem[i]) begin
        bad++;
        if (first < 0) first = i;
      end
    tests++;
    if (bad != 0) begin
      fails++;
      $display("FAIL %s: array mismatch at %0d actual %0d expected %0d",
               tag, first, dutMem[first], refMem[first]);
    end
  endtask

  // One idle cycle of strobes, with the model updated from the requirements.
  task automatic step(bit ld, logic [7:0] a, bit st, logic [7:0] d, bit rd, bit cm);
    logic [7:0] effA;
    addrLoad = ld; addrIn = a; dataValid = st; dataIn = d;
    readNext = rd; commitStart = cm;
    @(negedge clk);
    addrLoad = 0; dataValid = 0; readNext = 0; commitStart = 0;
    effA = ld ? a : refAddr;
    if (ld) refValid = '0;
    if (st) begin
      refLatch[effA[3:0]] = d;
      refValid[effA[3:0]] = 1'b1;
      refAddr = {effA[7:4], effA[3:0] + 4'd1};
    end else if (ld) refAddr = a;
    else if (rd) refAddr = refAddr + 8'd1;
  endtask

  // Called right after the cycle carrying commitStart.
  task automatic finishCommit(bit inject);
    int n = 0;
    int we0 = weCount;
    int exp = 0;
    while (busy) begin
      if (inject && n == 3) begin
        addrLoad = 1; addrIn = 8'hC3; dataValid = 1; dataIn = 8'h99;
        readNext = 1; commitStart = 1;
      end
      @(negedge clk);
      addrLoad = 0; dataValid = 0; readNext = 0; commitStart = 0;
      n++;
      if (n > 4 * WR) break;
    end
    for (int k = 0; k < 16; k++) begin
      logic [7:0] a = {refAddr[7:4], 4'(k)};
      if (refValid[k] && allowed(protMode, a)) begin
        refMem[a] = refLatch[k];
        exp++;
      end
    end
    refValid = '0;
    chk("R7 busy length", n, WR);
    chk("R8 write count", weCount - we0, exp);
    chkMem("R8 array contents");
    chk("R12 address after commit", int'(curAddr), int'(refAddr));
    if (inject) begin
      @(negedge clk);
      chk("R10 no second cycle", int'(busy), 0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int we0;
    void'($urandom(32'd2718));
    rstN = 0; addrLoad = 0; dataValid = 0; readNext = 0; commitStart = 0;
    addrIn = 0; dataIn = 0; protMode = 0;
    for (int i = 0; i < 256; i++) refMem[i] = 8'h00;
    for (int i = 0; i < 16; i++) refLatch[i] = 8'h00;
    refValid = '0; refAddr = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);

    // R1 reset state
    chk("R1 curAddr", int'(curAddr), 0);
    chk("R1 busy", int'(busy), 0);
    chk("R1 memWe", int'(memWe), 0);

    // R3 partial page with in-page wrap
    step(1, 8'h3E, 0, 0, 0, 0);
    chk("R2 load", int'(curAddr), 8'h3E);
    step(0, 0, 1, 8'h11, 0, 0);
    step(0, 0, 1, 8'h22, 0, 0);
    chk("R3 wrap to page start", int'(curAddr), 8'h30);
    step(0, 0, 1, 8'h33, 0, 0);
    step(0, 0, 1, 8'h44, 0, 0);
    chk("R3 address after four bytes", int'(curAddr), int'(refAddr));
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);

    // R4 eighteen bytes overwrite slots 0 and 1
    step(1, 8'h50, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) step(0, 0, 1, 8'(8'hA0 + i), 0, 0);
    chk("R4 address after overflow", int'(curAddr), 8'h52);
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);
    chk("R4 slot 0 holds latest", int'(dutMem[8'h50]), 8'hB0);

    // R5 full-address read wrap; R2 load discards bytes
    step(1, 8'h60, 0, 0, 0, 0);
    step(0, 0, 1, 8'h5A, 0, 0);
    step(1, 8'hFE, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1, 0);
    chk("R5 read wrap FF to 00", int'(curAddr), 8'h01);
    we0 = weCount;
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);
    chk("R2 discarded bytes not written", weCount - we0, 0);

    // R6 same-cycle strobes
    step(1, 8'h7A, 1, 8'hAA, 0, 0);
    chk("R6 load with store", int'(curAddr), 8'h7B);
    step(1, 8'h20, 0, 0, 1, 0);
    chk("R6 load beats read", int'(curAddr), 8'h20);
    step(1, 8'h8F, 0, 0, 0, 0);
    step(0, 0, 1, 8'h77, 1, 0);
    chk("R6 store beats read", int'(curAddr), 8'h80);
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);

    // R9 protected lower half: nothing written, timing unchanged
    protMode = 1;
    step(1, 8'h70, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++) step(0, 0, 1, 8'hE0, 0, 0);
    we0 = weCount;
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);
    chk("R9 protected writes suppressed", weCount - we0, 0);
    protMode = 0;

    // R13 store in the same cycle as commit
    step(1, 8'h94, 0, 0, 0, 0);
    step(0, 0, 1, 8'h3C, 0, 1);
    finishCommit(0);
    chk("R13 commit includes same-cycle byte", int'(dutMem[8'h94]), 8'h3C);

    // R10 strobes during busy ignored
    step(1, 8'hA0, 0, 0, 0, 0);
    step(0, 0, 1, 8'h12, 0, 0);
    step(0, 0, 0, 0, 0, 1);
    finishCommit(1);

    // R11 mask emptied: second commit writes nothing
    we0 = weCount;
    step(0, 0, 0, 0, 0, 1);
    finishCommit(0);
    chk("R11 empty commit", weCount - we0, 0);

    // Random page writes and random read runs
    for (int it = 0; it < 25; it++) begin
      logic [7:0] a = 8'($urandom);
      int n = 1 + int'($urandom % 20);
      protMode = int'($urandom % 2);
      step(1, a, 0, 0, 0, 0);
      for (int i = 0; i < n; i++) step(0, 0, 1, 8'($urandom), 0, 0);
      chk("R3 random address", int'(curAddr), int'(refAddr));
      step(0, 0, 0, 0, 0, 1);
      finishCommit(0);
      a = 8'($urandom);
      n = int'($urandom % 6);
      step(1, a, 0, 0, 0, 0);
      for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, 0);
      chk("R5 random read run", int'(curAddr), int'(8'(a + 8'(n))));
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule